// File: doc/BRIEF.md
# Sequence-unlocked configuration register window

This block sits between a host I/O port and a disk drive interface. In normal operation it is transparent: every host access is passed to the drive side unchanged, and read data from the drive is returned to the host. A small bank of configuration registers is hidden behind this port. The bank becomes visible only after the host performs a fixed unlock sequence made of ordinary-looking bus accesses.

After the sequence is complete, the window is open. Host accesses then stop reaching the drive. Byte accesses at small offsets select internal registers instead: read-cycle timing, write-cycle timing, a control byte, a read-only version byte and a miscellaneous byte. Bit 0 of the miscellaneous byte chooses which of two timing sets the timing offsets reach. A dedicated closing write makes the port transparent again. The timing values and the control and miscellaneous bytes are exported for a separate timing engine.

Top module: `cfg_window_gate`

## Requirements
- R1: On synchronous active-low reset the window is closed, the sequence count is zero, and every stored register (both timing sets, control, miscellaneous) is 0, so set A (set_b = 0) is selected.
- R2: While the window is closed, drv_valid equals bus_valid, drv_write, drv_wide, drv_offs and drv_wdata equal their bus counterparts, bus_rdata equals drv_rdata, and no configuration register changes. This includes the accesses that form the unlock sequence.
- R3: The window opens at the clock edge of a byte write (bus_wide = 0) whose low data byte is 0x03 at offset 2, provided the two accesses just before it were 16-bit reads (bus_wide = 1) at offset 1. Three or more such reads in a row also satisfy this. Reads are visible from the next cycle.
- R4: Any other access (a byte read at offset 1, any write, or a read at another offset) placed between those reads and the 0x03 write clears the sequence count, so the write does not open the window. Cycles with bus_valid low do not affect the count.
- R5: While the window is open, drv_valid stays low.
- R6: While the window is open, a read returns the addressed register in bits 7:0 with bits 15:8 zero. Offset 0 is read timing, offset 1 is write timing, offset 3 is control and offset 6 is miscellaneous. Writes to these offsets store the low data byte at the next edge.
- R7: While the window is open, offset 5 always reads the VERSION parameter (default 0x00), and writes to it are ignored. Offsets 2, 4 and 7 read 0x00.
- R8: Offsets 0 and 1 reach timing set A when miscellaneous bit 0 is 0 and set B when it is 1. The two sets hold independent values. set_b shows the current selection.
- R9: A byte write of 0x83 at offset 2 while the window is open closes it from the next cycle. Any other write at offset 2 leaves the window open and changes nothing.
- R10: Register contents are kept while the window is closed and are seen again after a later unlock. The exported timing, control and miscellaneous outputs always show the stored values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Host access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_wide | input | 1 | 1 = 16-bit access, 0 = byte access |
| bus_offs | input | 3 | Register offset within the port |
| bus_wdata | input | DATA_W | Host write data |
| bus_rdata | output | DATA_W | Host read data |
| drv_valid | output | 1 | Access strobe toward the drive |
| drv_write | output | 1 | Write flag toward the drive |
| drv_wide | output | 1 | Width flag toward the drive |
| drv_offs | output | 3 | Offset toward the drive |
| drv_wdata | output | DATA_W | Write data toward the drive |
| drv_rdata | input | DATA_W | Read data from the drive |
| win_open | output | 1 | Configuration window is open |
| set_b | output | 1 | Timing set B selected |
| rd_tim_a | output | 8 | Read timing, set A |
| wr_tim_a | output | 8 | Write timing, set A |
| rd_tim_b | output | 8 | Read timing, set B |
| wr_tim_b | output | 8 | Write timing, set B |
| ctrl_byte | output | 8 | Control register |
| misc_byte | output | 8 | Miscellaneous register |

## Verification
Pass-through signals and configuration read data are combinational, so they are due in the same cycle as the access. The bench samples them 1 ns after driving the inputs, before the clock edge. Window state, selected set and stored registers change only at the edge that ends an access, so they are due in the next cycle. The bench updates its model after that edge and compares those outputs at the sample point of the following access. Random traffic mixes complete and broken unlock sequences, closing and non-closing writes at offset 2, and idle gaps, all checked against the same model.

// File: rtl/cfg_gate_pkg.sv
`timescale 1ns/1ps
// Shared constants for the configuration window gate.
// Assumes a 3-bit port offset and byte-wide configuration registers.
package cfg_gate_pkg;
    localparam int OFFS_W = 3;
    localparam int CFG_W  = 8;
    localparam int NSETS  = 2;
    // Offsets decoded while the window is open
    localparam logic [OFFS_W-1:0] OFF_RTIM  = 3'd0;
    localparam logic [OFFS_W-1:0] OFF_WTIM  = 3'd1;
    localparam logic [OFFS_W-1:0] OFF_GATE  = 3'd2;
    localparam logic [OFFS_W-1:0] OFF_CTRL  = 3'd3;
    localparam logic [OFFS_W-1:0] OFF_STRAP = 3'd5;
    localparam logic [OFFS_W-1:0] OFF_MISC  = 3'd6;
    // Offset whose 16-bit reads arm the unlock
    localparam logic [OFFS_W-1:0] OFF_PROBE = 3'd1;
endpackage

// File: rtl/cfg_unlock_seq.sv
`timescale 1ns/1ps
// Unlock sequence detector. It counts consecutive 16-bit reads at the
// probe offset, opens the window on the key byte write once enough
// probes are seen, and closes the window on the lock byte write.
// Assumes one access per cycle in which acc_valid is high.
module cfg_unlock_seq
    import cfg_gate_pkg::*;
#(
    parameter int          PROBE_COUNT = 2,
    parameter logic [7:0]  UNLOCK_KEY  = 8'h03,
    parameter logic [7:0]  LOCK_KEY    = 8'h83
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic              acc_wide,
    input  logic [OFFS_W-1:0] acc_offs,
    input  logic [CFG_W-1:0]  acc_byte,
    output logic              open_o
);
    localparam int CNT_W = $clog2(PROBE_COUNT + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(PROBE_COUNT);

    logic             open_q;
    logic [CNT_W-1:0] cnt_q;
    logic             is_probe, is_key, is_lock;

    // Classify the current access
    always_comb begin
        is_probe = !acc_write && acc_wide && (acc_offs == OFF_PROBE);
        is_key   = acc_write && !acc_wide && (acc_offs == OFF_GATE) && (acc_byte == UNLOCK_KEY);
        is_lock  = acc_write && !acc_wide && (acc_offs == OFF_GATE) && (acc_byte == LOCK_KEY);
    end

    // Advance the probe count and open or close the window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= 1'b0;
            cnt_q  <= '0;
        end else if (acc_valid) begin
            if (open_q) begin
                if (is_lock) open_q <= 1'b0;
                cnt_q <= '0;
            end else if (is_probe) begin
                if (cnt_q != CNT_FULL) cnt_q <= cnt_q + 1'b1;
            end else begin
                if (is_key && (cnt_q == CNT_FULL)) open_q <= 1'b1;
                cnt_q <= '0;
            end
        end
    end

    assign open_o = open_q;

    // R3: the window only opens on a key write after a full probe count
    p_open_needs_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(open_q) |-> ($past(acc_valid) && $past(is_key) && ($past(cnt_q) == CNT_FULL)));

    // R9: a lock write while open closes the window
    p_lock_closes_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (open_q && acc_valid && is_lock) |=> !open_q);

    // R4: the count never passes its limit
    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_FULL);
endmodule

// File: rtl/cfg_regs.sv
`timescale 1ns/1ps
// Configuration register file behind the window. It holds two timing
// sets, a control byte and a misc byte whose bit 0 picks the set.
// Assumes writes arrive only as qualified by open_i.
module cfg_regs
    import cfg_gate_pkg::*;
#(
    parameter logic [7:0] VERSION = 8'h00
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        open_i,
    input  logic                        acc_valid,
    input  logic                        acc_write,
    input  logic [OFFS_W-1:0]           acc_offs,
    input  logic [CFG_W-1:0]            acc_byte,
    output logic [CFG_W-1:0]            rdata_o,
    output logic [NSETS-1:0][CFG_W-1:0] rd_tim_o,
    output logic [NSETS-1:0][CFG_W-1:0] wr_tim_o,
    output logic [CFG_W-1:0]            ctrl_o,
    output logic [CFG_W-1:0]            misc_o
);
    logic [NSETS-1:0][CFG_W-1:0] rd_tim_q, wr_tim_q;
    logic [CFG_W-1:0]            ctrl_q, misc_q;
    logic                        wr_en;
    logic                        sel;

    assign wr_en = open_i && acc_valid && acc_write;
    assign sel   = misc_q[0];

    // One timing set per generate slice, written only when selected
    for (genvar s = 0; s < NSETS; s++) begin : g_set
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rd_tim_q[s] <= '0;
                wr_tim_q[s] <= '0;
            end else if (wr_en && (sel == s[0])) begin
                if (acc_offs == OFF_RTIM) rd_tim_q[s] <= acc_byte;
                if (acc_offs == OFF_WTIM) wr_tim_q[s] <= acc_byte;
            end
        end
    end

    // Shared control and misc bytes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            misc_q <= '0;
        end else if (wr_en) begin
            if (acc_offs == OFF_CTRL) ctrl_q <= acc_byte;
            if (acc_offs == OFF_MISC) misc_q <= acc_byte;
        end
    end

    // Read data mux by offset
    always_comb begin
        case (acc_offs)
            OFF_RTIM:  rdata_o = rd_tim_q[sel];
            OFF_WTIM:  rdata_o = wr_tim_q[sel];
            OFF_CTRL:  rdata_o = ctrl_q;
            OFF_STRAP: rdata_o = VERSION;
            OFF_MISC:  rdata_o = misc_q;
            default:   rdata_o = '0;
        endcase
    end

    assign rd_tim_o = rd_tim_q;
    assign wr_tim_o = wr_tim_q;
    assign ctrl_o   = ctrl_q;
    assign misc_o   = misc_q;

    // R10: without a window write, nothing stored changes
    p_hold_closed_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(open_i && acc_valid && acc_write) |=>
        ($stable(rd_tim_q) && $stable(wr_tim_q) && $stable(ctrl_q) && $stable(misc_q)));

    // R8: the set not selected is untouched by a timing write
    p_other_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !sel) |=> ($stable(rd_tim_q[1]) && $stable(wr_tim_q[1])));
endmodule

// File: rtl/cfg_window_gate.sv
`timescale 1ns/1ps
// Top of the configuration window gate. Closed: host accesses pass to
// the drive side unchanged. Open: the drive is cut off and accesses
// reach the configuration registers through the low data byte.
// Assumes one host access per cycle with bus_valid high.
module cfg_window_gate
    import cfg_gate_pkg::*;
#(
    parameter int         DATA_W      = 16,
    parameter int         PROBE_COUNT = 2,
    parameter logic [7:0] UNLOCK_KEY  = 8'h03,
    parameter logic [7:0] LOCK_KEY    = 8'h83,
    parameter logic [7:0] VERSION     = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic              bus_wide,
    input  logic [OFFS_W-1:0] bus_offs,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              drv_valid,
    output logic              drv_write,
    output logic              drv_wide,
    output logic [OFFS_W-1:0] drv_offs,
    output logic [DATA_W-1:0] drv_wdata,
    input  logic [DATA_W-1:0] drv_rdata,
    output logic              win_open,
    output logic              set_b,
    output logic [CFG_W-1:0]  rd_tim_a,
    output logic [CFG_W-1:0]  wr_tim_a,
    output logic [CFG_W-1:0]  rd_tim_b,
    output logic [CFG_W-1:0]  wr_tim_b,
    output logic [CFG_W-1:0]  ctrl_byte,
    output logic [CFG_W-1:0]  misc_byte
);
    localparam int PAD_W = DATA_W - CFG_W;

    logic                        open_w;
    logic [CFG_W-1:0]            cfg_rdata;
    logic [NSETS-1:0][CFG_W-1:0] rd_tim_w, wr_tim_w;
    logic [CFG_W-1:0]            misc_w;

    // Sequence detector
    cfg_unlock_seq #(
        .PROBE_COUNT (PROBE_COUNT),
        .UNLOCK_KEY  (UNLOCK_KEY),
        .LOCK_KEY    (LOCK_KEY)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_valid (bus_valid),
        .acc_write (bus_write),
        .acc_wide  (bus_wide),
        .acc_offs  (bus_offs),
        .acc_byte  (bus_wdata[CFG_W-1:0]),
        .open_o    (open_w)
    );

    // Register file
    cfg_regs #(
        .VERSION (VERSION)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .open_i    (open_w),
        .acc_valid (bus_valid),
        .acc_write (bus_write),
        .acc_offs  (bus_offs),
        .acc_byte  (bus_wdata[CFG_W-1:0]),
        .rdata_o   (cfg_rdata),
        .rd_tim_o  (rd_tim_w),
        .wr_tim_o  (wr_tim_w),
        .ctrl_o    (ctrl_byte),
        .misc_o    (misc_w)
    );

    // Drive-side pass-through, strobe cut while open
    assign drv_valid = bus_valid && !open_w;
    assign drv_write = bus_write;
    assign drv_wide  = bus_wide;
    assign drv_offs  = bus_offs;
    assign drv_wdata = bus_wdata;

    // Host read data source
    assign bus_rdata = open_w ? {{PAD_W{1'b0}}, cfg_rdata} : drv_rdata;

    assign win_open  = open_w;
    assign misc_byte = misc_w;
    assign set_b     = misc_w[0];
    assign rd_tim_a  = rd_tim_w[0];
    assign wr_tim_a  = wr_tim_w[0];
    assign rd_tim_b  = rd_tim_w[1];
    assign wr_tim_b  = wr_tim_w[1];

    // R5: no drive access while the window is open
    p_drive_cut_r5: assert property (@(posedge clk) disable iff (!rst_n)
        win_open |-> !drv_valid);

    // R2: closed window passes strobe and read data
    p_pass_closed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !win_open |-> ((drv_valid == bus_valid) && (bus_rdata == drv_rdata)));

    // R7: the strap offset reads the version byte
    p_strap_ver_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (win_open && bus_valid && !bus_write && (bus_offs == OFF_STRAP)) |->
        (bus_rdata == {{PAD_W{1'b0}}, VERSION}));
endmodule

// File: tb/tb_cfg_window_gate.sv
`timescale 1ns/1ps
module tb_cfg_window_gate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0, bus_wide = 1'b0;
    logic [2:0]  bus_offs = '0;
    logic [15:0] bus_wdata = '0, drv_rdata = '0;
    logic [15:0] bus_rdata, drv_wdata;
    logic        drv_valid, drv_write, drv_wide, win_open, set_b;
    logic [2:0]  drv_offs;
    logic [7:0]  rd_tim_a, wr_tim_a, rd_tim_b, wr_tim_b, ctrl_byte, misc_byte;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // model state
    bit         m_open;
    int         m_cnt;
    logic [7:0] m_rt [2];
    logic [7:0] m_wt [2];
    logic [7:0] m_ctrl, m_misc;

    always #2.5 clk = ~clk;

    cfg_window_gate dut (
        .clk(clk), .rst_n(rst_n),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_wide(bus_wide),
        .bus_offs(bus_offs), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .drv_valid(drv_valid), .drv_write(drv_write), .drv_wide(drv_wide),
        .drv_offs(drv_offs), .drv_wdata(drv_wdata), .drv_rdata(drv_rdata),
        .win_open(win_open), .set_b(set_b),
        .rd_tim_a(rd_tim_a), .wr_tim_a(wr_tim_a), .rd_tim_b(rd_tim_b), .wr_tim_b(wr_tim_b),
        .ctrl_byte(ctrl_byte), .misc_byte(misc_byte)
    );

    task automatic ck(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] exp_byte(input logic [2:0] o);
        case (o)
            3'd0: return m_rt[m_misc[0]];
            3'd1: return m_wt[m_misc[0]];
            3'd3: return m_ctrl;
            3'd5: return 8'h00;
            3'd6: return m_misc;
            default: return 8'h00;
        endcase
    endfunction

    function automatic string rd_tag(input logic [2:0] o);
        case (o)
            3'd0, 3'd1: return "R8 timing read";
            3'd5, 3'd2, 3'd4, 3'd7: return "R7 fixed read";
            default: return "R6 register read";
        endcase
    endfunction

    task automatic model_reset();
        m_open = 0; m_cnt = 0; m_ctrl = 0; m_misc = 0;
        for (int s = 0; s < 2; s++) begin m_rt[s] = 0; m_wt[s] = 0; end
    endtask

    task automatic check_state();
        ck("R3 window state", win_open, m_open);
        ck("R8 set select", set_b, m_misc[0]);
        ck("R10 rd_tim_a", rd_tim_a, m_rt[0]);
        ck("R10 wr_tim_a", wr_tim_a, m_wt[0]);
        ck("R10 rd_tim_b", rd_tim_b, m_rt[1]);
        ck("R10 wr_tim_b", wr_tim_b, m_wt[1]);
        ck("R10 ctrl", ctrl_byte, m_ctrl);
        ck("R10 misc", misc_byte, m_misc);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0; bus_valid = 0;
        @(negedge clk); @(negedge clk); rst_n = 1;
        model_reset();
        #1 check_state();
    endtask

    // one access: drive, check same-cycle outputs, then update the model
    task automatic acc(input bit w, input bit wd, input logic [2:0] o, input logic [15:0] d);
        @(negedge clk);
        bus_valid = 1; bus_write = w; bus_wide = wd; bus_offs = o; bus_wdata = d;
        drv_rdata = 16'($urandom);
        #1;
        check_state();
        if (!m_open) begin
            ck("R2 drv_valid", drv_valid, 1'b1);
            ck("R2 drv fields", {drv_write, drv_wide, drv_offs, drv_wdata}, {w, wd, o, d});
            ck("R2 rdata pass", bus_rdata, drv_rdata);
        end else begin
            ck("R5 drive cut", drv_valid, 1'b0);
            if (!w) ck(rd_tag(o), bus_rdata, {8'h00, exp_byte(o)});
        end
        @(posedge clk); #1;
        bus_valid = 0;
        if (m_open) begin
            if (w && !wd && o == 3'd2 && d[7:0] == 8'h83) m_open = 0;
            else if (w) begin
                case (o)
                    3'd0: m_rt[m_misc[0]] = d[7:0];
                    3'd1: m_wt[m_misc[0]] = d[7:0];
                    3'd3: m_ctrl = d[7:0];
                    3'd6: m_misc = d[7:0];
                    default: ;
                endcase
            end
            m_cnt = 0;
        end else if (!w && wd && o == 3'd1) begin
            if (m_cnt < 2) m_cnt++;
        end else begin
            if (w && !wd && o == 3'd2 && d[7:0] == 8'h03 && m_cnt == 2) m_open = 1;
            m_cnt = 0;
        end
    endtask

    task automatic unlock();
        acc(0, 1, 3'd1, 16'h0);
        acc(0, 1, 3'd1, 16'h0);
        acc(1, 0, 3'd2, 16'h0003);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd4242));
        model_reset();
        do_reset();                                   // R1 reset state
        ck("R1 closed after reset", win_open, 1'b0);
        acc(0, 1, 3'd0, 16'h0);                       // R2 plain pass-through
        acc(1, 1, 3'd6, 16'h1234);                    // R2 closed write ignored by regs
        // R4: byte reads do not count
        acc(0, 0, 3'd1, 0); acc(0, 0, 3'd1, 0); acc(1, 0, 3'd2, 16'h0003);
        ck("R4 byte probes rejected", win_open, 1'b0);
        // R4: interleaved access breaks the sequence
        acc(0, 1, 3'd1, 0); acc(0, 1, 3'd3, 0); acc(0, 1, 3'd1, 0); acc(1, 0, 3'd2, 16'h0003);
        ck("R4 broken sequence", win_open, 1'b0);
        // R4: idle cycles do not break it; R3 opens
        acc(0, 1, 3'd1, 0); idle(3); acc(0, 1, 3'd1, 0); idle(2); acc(1, 0, 3'd2, 16'hFF03);
        ck("R3 opened", win_open, 1'b1);
        // R6/R8: program set A then set B
        acc(1, 0, 3'd6, 16'h0000); acc(1, 0, 3'd0, 16'h00A1); acc(1, 0, 3'd1, 16'h00A2);
        acc(1, 0, 3'd6, 16'h0001); acc(1, 0, 3'd0, 16'h00B1); acc(1, 0, 3'd1, 16'h00B2);
        acc(0, 0, 3'd0, 0); acc(0, 0, 3'd1, 0);
        acc(1, 0, 3'd3, 16'h0085); acc(0, 0, 3'd3, 0);
        acc(1, 0, 3'd6, 16'h0000); acc(0, 0, 3'd0, 0); acc(0, 1, 3'd1, 0);
        // R7: strap is read-only
        acc(1, 0, 3'd5, 16'h00FF); acc(0, 0, 3'd5, 0); acc(0, 0, 3'd4, 0); acc(0, 0, 3'd2, 0);
        // R9: other offset-2 writes keep it open
        acc(1, 0, 3'd2, 16'h0055); acc(1, 0, 3'd2, 16'h0003); acc(1, 1, 3'd2, 16'h0083);
        ck("R9 still open", win_open, 1'b1);
        acc(1, 0, 3'd2, 16'h0083);
        ck("R9 closed", win_open, 1'b0);
        // R10: closed writes leave registers intact, reopen sees them
        acc(1, 0, 3'd0, 16'h00EE); acc(1, 0, 3'd6, 16'h0001);
        unlock(); acc(0, 0, 3'd0, 0); acc(0, 0, 3'd6, 0);
        // R1: reset while open
        do_reset();
        ck("R1 closed after mid-run reset", win_open, 1'b0);
        // R3: three probes still unlock
        acc(0, 1, 3'd1, 0); acc(0, 1, 3'd1, 0); acc(0, 1, 3'd1, 0); acc(1, 0, 3'd2, 16'h0003);
        ck("R3 saturated count opens", win_open, 1'b1);
        // random phase
        for (int k = 0; k < 800; k++) begin
            int r;
            r = $urandom % 12;
            if (r < 2 && !m_open) unlock();
            else if (r == 2) acc(1, 0, 3'd2, 16'h0083);
            else if (r == 3) idle(1 + $urandom % 3);
            else if (r == 4) acc(0, 1, 3'd1, 16'h0);
            else begin
                logic [15:0] d;
                d = 16'($urandom);
                if (($urandom % 4) == 0) d[7:0] = 8'h03;
                acc(1'($urandom), 1'($urandom), 3'($urandom), d);
            end
        end
        idle(2);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(5ns * 150000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule